// File: doc/BRIEF.md
# Probabilistic Adjacent Row Refresher

This block sits on the command path between a memory controller's scheduler and the DRAM command bus. It watches every row close issued by the scheduler. When a precharge ends a row that the scheduler had activated, the block draws a 16-bit pseudo-random value. If that value is below a threshold that software can program, the block queues refreshes of the rows that are physically next to the closed row in the same bank. The chance of a refresh per close is therefore threshold / 65536. The block keeps no per-row history. Its state is the generator, the configuration, a per-bank open-row record and a four-entry queue of pending refreshes.

Physical neighbours come from a remap table loaded at configuration time. The table gives the physical position of each logical row, because the DRAM may place rows out of logical order. Each queued refresh goes out as an activate followed by a precharge, with a programmable minimum gap between the two.

Both command streams follow valid/ready rules. A scheduler command always has the bus. It passes straight through, and `sch_ready` mirrors `bus_ready`. A refresh is offered only while `sch_valid` is low. While `bus_ready` is low and the scheduler is idle, the refresh offer holds its command, bank and row. A scheduler request may take over the bus from a refresh offer that has not yet been accepted. The queued entry is kept until its precharge is accepted.

Top module: `para_refresher`

## Requirements
- R1: A trigger is a scheduler precharge (`sch_cmd`=2) accepted on the bus (`sch_valid` and `bus_ready` high) to a bank whose row was opened by an accepted scheduler activate (`sch_cmd`=1). A precharge to a closed bank, a read/write (`sch_cmd`=3) and the block's own commands are not triggers. `trig_count` counts triggers.
- R2: The generator is a 16-bit Galois LFSR. Each step shifts right by one and XORs in 0xB400 when the bit shifted out was 1. Its reset state is 0x0001. A `cfg_seed_load` pulse replaces the state with `cfg_seed`, or with 0x0001 when the seed is zero. The generator steps once per trigger, and the draw for a trigger is the state before that step.
- R3: Neighbour refreshes are queued only when the draw is less than `cfg_threshold`, as unsigned numbers. A threshold of zero never queues anything.
- R4: Let p be the table's physical position for the closed logical row. The lower neighbour is the logical row placed at p-1 and the upper neighbour is the logical row placed at p+1. The lower one is queued first. A neighbour is skipped at p=0 and at p=ROWS-1. After reset the table is the identity map. A `cfg_map_we` cycle sets the entry for logical row `cfg_map_lrow` to `cfg_map_prow`.
- R5: The block issues each queued entry in queue order as an activate (`bus_cmd`=1) and then a precharge (`bus_cmd`=2) to the entry's bank and row. It never starts a second activate before the matching precharge.
- R6: A refresh precharge is accepted no sooner than `cfg_gap`+2 cycles after its activate was accepted.
- R7: While `sch_valid` is high the bus carries the scheduler command, and no refresh command is accepted. While a refresh is offered with `bus_ready` low and `sch_valid` low, the offer stays unchanged.
- R8: The queue holds 4 entries. A neighbour that finds the queue full is dropped and is never issued, and `overflow` then goes high and stays high until reset.
- R9: `refr_count` counts refresh activates accepted on the bus.
- R10: After reset, `bus_valid`, `overflow`, `trig_count` and `refr_count` are all zero while the scheduler is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_threshold | input | 16 | Refresh probability threshold |
| cfg_gap | input | GAP_W | Extra cycles between refresh activate and precharge |
| cfg_seed_load | input | 1 | Load generator seed this cycle |
| cfg_seed | input | 16 | Generator seed |
| cfg_map_we | input | 1 | Write one remap table entry |
| cfg_map_lrow | input | ROW_W | Logical row of the entry |
| cfg_map_prow | input | ROW_W | Physical position of that row |
| sch_valid | input | 1 | Scheduler command valid |
| sch_ready | output | 1 | Scheduler command accepted |
| sch_cmd | input | 2 | Scheduler command: 1 activate, 2 precharge, 3 read/write |
| sch_bank | input | BANK_W | Scheduler bank |
| sch_row | input | ROW_W | Scheduler row |
| bus_valid | output | 1 | Command bus valid |
| bus_ready | input | 1 | Command bus ready |
| bus_cmd | output | 2 | Command bus code |
| bus_bank | output | BANK_W | Command bus bank |
| bus_row | output | ROW_W | Command bus row |
| overflow | output | 1 | Sticky flag: a neighbour refresh was dropped |
| trig_count | output | CNT_W | Number of triggers |
| refr_count | output | CNT_W | Number of refresh activates issued |

## Verification
Two things can meet in the same cycle: the scheduler asking for the bus and a pending refresh waiting to go out. Several triggers can also land while the scheduler holds the bus, so the queue fills up. The bench keeps `sch_valid` high across three back-to-back activate/precharge pairs, which holds the refreshes back. It checks that no refresh activate got through during that stretch, then releases the bus. The scoreboard then expects the first four neighbours in order and none of the dropped ones, with `overflow` set. A separate step lowers `bus_ready` while a refresh is on offer and checks that the offer holds.

// File: rtl/para_pkg.sv
package para_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_PRE  = 2'd2,
    CMD_RW   = 2'd3
  } cmd_e;

  localparam int          RNG_W    = 16;
  localparam logic [15:0] RNG_TAPS = 16'hB400;
  localparam logic [15:0] RNG_INIT = 16'h0001;
endpackage

// File: rtl/para_lfsr.sv
module para_lfsr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   TAPS = 16'hB400,
  parameter logic [W-1:0]   INIT = 16'h0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);
  logic [W-1:0] nxt;

  // Galois form: shift right, fold the taps back in on a one
  always_comb begin
    nxt = {1'b0, state[W-1:1]};
    if (state[0]) nxt = nxt ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= INIT;
    else if (load)    state <= (seed == '0) ? INIT : seed;
    else if (step)    state <= nxt;
  end
endmodule

// File: rtl/para_adj_map.sv
module para_adj_map #(
  parameter int ROW_W = 4,
  localparam int ROWS = 1 << ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [ROW_W-1:0] wr_lrow,
  input  logic [ROW_W-1:0] wr_prow,
  input  logic [ROW_W-1:0] look_row,
  output logic             lo_valid,
  output logic [ROW_W-1:0] lo_row,
  output logic             hi_valid,
  output logic [ROW_W-1:0] hi_row
);
  logic [ROW_W-1:0] place [ROWS];
  logic [ROW_W-1:0] pos, pos_dn, pos_up;
  logic             found_lo, found_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < ROWS; l++) place[l] <= ROW_W'(l);
    end else if (we) begin
      place[wr_lrow] <= wr_prow;
    end
  end

  // reverse search: which logical row sits at each neighbouring slot
  always_comb begin
    pos      = place[look_row];
    pos_dn   = pos - ROW_W'(1);
    pos_up   = pos + ROW_W'(1);
    found_lo = 1'b0;
    found_hi = 1'b0;
    lo_row   = '0;
    hi_row   = '0;
    for (int l = 0; l < ROWS; l++) begin
      if (place[l] == pos_dn) begin
        found_lo = 1'b1;
        lo_row   = ROW_W'(l);
      end
      if (place[l] == pos_up) begin
        found_hi = 1'b1;
        hi_row   = ROW_W'(l);
      end
    end
    lo_valid = found_lo && (pos != '0);
    hi_valid = found_hi && (pos != '1);
  end
endmodule

// File: rtl/para_refq.sv
module para_refq #(
  parameter int DW    = 6,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_a,
  input  logic [DW-1:0] data_a,
  input  logic          push_b,
  input  logic [DW-1:0] data_b,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          not_empty,
  output logic          drop
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic             acc_a, acc_b, pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // space freed by a pop is reused from the next cycle on
  assign acc_a     = push_a && (count < FULL);
  assign acc_b     = push_b && ((count + CNT_W'(acc_a)) < FULL);
  assign pop_ok    = pop && not_empty;
  assign not_empty = (count != '0);
  assign head      = mem[rd_ptr];
  assign drop      = (push_a && !acc_a) || (push_b && !acc_b);

  always_ff @(posedge clk) begin
    if (acc_a) mem[wr_ptr] <= data_a;
    if (acc_b) mem[acc_a ? bump(wr_ptr) : wr_ptr] <= data_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (acc_a && acc_b)      wr_ptr <= bump(bump(wr_ptr));
      else if (acc_a || acc_b) wr_ptr <= bump(wr_ptr);
      if (pop_ok) rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(acc_a) + CNT_W'(acc_b) - CNT_W'(pop_ok);
    end
  end
endmodule

// File: rtl/para_issue.sv
module para_issue
  import para_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  parameter int GAP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_valid,
  input  logic [BANK_W-1:0] q_bank,
  input  logic [ROW_W-1:0]  q_row,
  input  logic [GAP_W-1:0]  gap,
  input  logic              grant,
  output logic              ref_valid,
  output logic [1:0]        ref_cmd,
  output logic [BANK_W-1:0] ref_bank,
  output logic [ROW_W-1:0]  ref_row,
  output logic              pop,
  output logic              act_fire
);
  typedef enum logic [1:0] {ST_ACT, ST_WAIT, ST_PRE} st_e;
  st_e              st;
  logic [GAP_W-1:0] wait_cnt;

  assign ref_valid = (st == ST_PRE) || (st == ST_ACT && q_valid);
  assign ref_cmd   = (st == ST_PRE) ? CMD_PRE : CMD_ACT;
  assign ref_bank  = q_bank;
  assign ref_row   = q_row;
  assign act_fire  = (st == ST_ACT) && q_valid && grant;
  assign pop       = (st == ST_PRE) && grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_ACT;
      wait_cnt <= '0;
    end else begin
      case (st)
        ST_ACT:  if (act_fire) begin
                   st       <= ST_WAIT;
                   wait_cnt <= gap;
                 end
        ST_WAIT: if (wait_cnt == '0) st <= ST_PRE;
                 else                wait_cnt <= wait_cnt - GAP_W'(1);
        ST_PRE:  if (pop) st <= ST_ACT;
        default: st <= ST_ACT;
      endcase
    end
  end
endmodule

// File: rtl/para_refresher.sv
module para_refresher
  import para_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  parameter int QDEPTH = 4,
  parameter int GAP_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cfg_threshold,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              cfg_seed_load,
  input  logic [15:0]       cfg_seed,
  input  logic              cfg_map_we,
  input  logic [ROW_W-1:0]  cfg_map_lrow,
  input  logic [ROW_W-1:0]  cfg_map_prow,
  input  logic              sch_valid,
  output logic              sch_ready,
  input  logic [1:0]        sch_cmd,
  input  logic [BANK_W-1:0] sch_bank,
  input  logic [ROW_W-1:0]  sch_row,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [1:0]        bus_cmd,
  output logic [BANK_W-1:0] bus_bank,
  output logic [ROW_W-1:0]  bus_row,
  output logic              overflow,
  output logic [CNT_W-1:0]  trig_count,
  output logic [CNT_W-1:0]  refr_count
);
  localparam int BANKS = 1 << BANK_W;
  localparam int DW    = BANK_W + ROW_W;

  logic [BANKS-1:0] bank_open;
  logic [ROW_W-1:0] open_row [BANKS];
  logic             sch_fire, trigger, hit;
  logic [15:0]      draw;
  logic             lo_v, hi_v;
  logic [ROW_W-1:0] lo_r, hi_r;
  logic [DW-1:0]    q_head;
  logic             q_nempty, q_pop, q_drop;
  logic             ref_valid, act_fire, grant;
  logic [1:0]       ref_cmd;
  logic [BANK_W-1:0] ref_bank;
  logic [ROW_W-1:0] ref_row;

  assign sch_fire = sch_valid && bus_ready;
  assign trigger  = sch_fire && (sch_cmd == CMD_PRE) && bank_open[sch_bank];
  assign hit      = draw < cfg_threshold;

  // per-bank record of the row the scheduler currently holds open
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_open <= '0;
      for (int b = 0; b < BANKS; b++) open_row[b] <= '0;
    end else if (sch_fire) begin
      if (sch_cmd == CMD_ACT) begin
        bank_open[sch_bank] <= 1'b1;
        open_row[sch_bank]  <= sch_row;
      end else if (sch_cmd == CMD_PRE) begin
        bank_open[sch_bank] <= 1'b0;
      end
    end
  end

  para_lfsr #(.W(RNG_W), .TAPS(RNG_TAPS), .INIT(RNG_INIT)) rng_i (
    .clk(clk), .rst_n(rst_n), .load(cfg_seed_load), .seed(cfg_seed),
    .step(trigger), .state(draw)
  );

  para_adj_map #(.ROW_W(ROW_W)) map_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_map_we), .wr_lrow(cfg_map_lrow),
    .wr_prow(cfg_map_prow), .look_row(open_row[sch_bank]),
    .lo_valid(lo_v), .lo_row(lo_r), .hi_valid(hi_v), .hi_row(hi_r)
  );

  para_refq #(.DW(DW), .DEPTH(QDEPTH)) q_i (
    .clk(clk), .rst_n(rst_n),
    .push_a(trigger && hit && lo_v), .data_a({sch_bank, lo_r}),
    .push_b(trigger && hit && hi_v), .data_b({sch_bank, hi_r}),
    .pop(q_pop), .head(q_head), .not_empty(q_nempty), .drop(q_drop)
  );

  assign grant = bus_ready && !sch_valid;

  para_issue #(.BANK_W(BANK_W), .ROW_W(ROW_W), .GAP_W(GAP_W)) iss_i (
    .clk(clk), .rst_n(rst_n), .q_valid(q_nempty),
    .q_bank(q_head[DW-1:ROW_W]), .q_row(q_head[ROW_W-1:0]),
    .gap(cfg_gap), .grant(grant), .ref_valid(ref_valid), .ref_cmd(ref_cmd),
    .ref_bank(ref_bank), .ref_row(ref_row), .pop(q_pop), .act_fire(act_fire)
  );

  // scheduler has strict priority on the command bus
  assign sch_ready = bus_ready;
  assign bus_valid = sch_valid || ref_valid;
  assign bus_cmd   = sch_valid ? sch_cmd  : ref_cmd;
  assign bus_bank  = sch_valid ? sch_bank : ref_bank;
  assign bus_row   = sch_valid ? sch_row  : ref_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflow   <= 1'b0;
      trig_count <= '0;
      refr_count <= '0;
    end else begin
      if (q_drop)   overflow   <= 1'b1;
      if (trigger)  trig_count <= trig_count + CNT_W'(1);
      if (act_fire) refr_count <= refr_count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/para_refresher_chk.sv
module para_refresher_chk #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  parameter int GAP_W  = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [GAP_W-1:0]  cfg_gap,
  input logic              sch_valid,
  input logic [1:0]        sch_cmd,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [1:0]        bus_cmd,
  input logic [BANK_W-1:0] bus_bank,
  input logic [ROW_W-1:0]  bus_row,
  input logic              overflow,
  input logic [CNT_W-1:0]  trig_count,
  input logic [CNT_W-1:0]  refr_count
);
  logic              ref_hs, ref_open;
  logic [BANK_W-1:0] act_bank;
  logic [ROW_W-1:0]  act_row;
  logic [GAP_W:0]    since;

  assign ref_hs = bus_valid && bus_ready && !sch_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_open <= 1'b0;
      act_bank <= '0;
      act_row  <= '0;
      since    <= '0;
    end else begin
      if (ref_hs && bus_cmd == 2'd1) begin
        ref_open <= 1'b1;
        act_bank <= bus_bank;
        act_row  <= bus_row;
        since    <= (GAP_W+1)'(1);
      end else begin
        if (since != '1) since <= since + (GAP_W+1)'(1);
        if (ref_hs && bus_cmd == 2'd2) ref_open <= 1'b0;
      end
    end
  end

  // R5
  act_pairing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hs && bus_cmd == 2'd1) |-> !ref_open);

  // R5
  pre_pairing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hs && bus_cmd == 2'd2) |-> (ref_open && bus_bank == act_bank && bus_row == act_row));

  // R6
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hs && bus_cmd == 2'd2) |-> (since > {1'b0, cfg_gap}));

  // R7
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready && !sch_valid) |=>
      (sch_valid || (bus_valid && $stable(bus_cmd) && $stable(bus_bank) && $stable(bus_row))));

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9
  refr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hs && bus_cmd == 2'd1) |=> (refr_count == $past(refr_count) + CNT_W'(1)));

  // R1
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sch_valid && bus_ready && sch_cmd == 2'd2) |=> $stable(trig_count));
endmodule

bind para_refresher para_refresher_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .GAP_W(GAP_W), .CNT_W(CNT_W)
) chk_i (.*);

// File: tb/para_refresher_tb_top.sv
`timescale 1ns/1ps
module para_refresher_tb_top;
  localparam int GAP = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_threshold;
  logic [3:0]  cfg_gap;
  logic        cfg_seed_load;
  logic [15:0] cfg_seed;
  logic        cfg_map_we;
  logic [3:0]  cfg_map_lrow, cfg_map_prow;
  logic        sch_valid, sch_ready;
  logic [1:0]  sch_cmd;
  logic [1:0]  sch_bank;
  logic [3:0]  sch_row;
  logic        bus_valid, bus_ready;
  logic [1:0]  bus_cmd;
  logic [1:0]  bus_bank;
  logic [3:0]  bus_row;
  logic        overflow;
  logic [15:0] trig_count, refr_count;

  always #2 clk = ~clk;

  para_refresher dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_threshold(cfg_threshold), .cfg_gap(cfg_gap),
    .cfg_seed_load(cfg_seed_load), .cfg_seed(cfg_seed), .cfg_map_we(cfg_map_we),
    .cfg_map_lrow(cfg_map_lrow), .cfg_map_prow(cfg_map_prow),
    .sch_valid(sch_valid), .sch_ready(sch_ready), .sch_cmd(sch_cmd),
    .sch_bank(sch_bank), .sch_row(sch_row), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_cmd(bus_cmd), .bus_bank(bus_bank),
    .bus_row(bus_row), .overflow(overflow), .trig_count(trig_count),
    .refr_count(refr_count)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int act_cyc = 0;

  // reference model state
  logic [15:0] m_lfsr = 16'h0001;
  int          m_phys [16];
  int          m_occ  = 0;
  int          m_refr = 0;
  int          m_trig = 0;
  bit          m_ovf  = 0;
  bit          b_open [4];
  int          b_row  [4];
  logic [5:0]  exp_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] rng_step(input logic [15:0] s);
    logic [15:0] r;
    r = s >> 1;
    if (s[0]) r = r ^ 16'hB400;
    return r;
  endfunction

  function automatic int slot_owner(input int p);
    for (int l = 0; l < 16; l++) if (m_phys[l] == p) return l;
    return -1;
  endfunction

  task automatic model_push(input int bank, input int row);
    if (m_occ < 4) begin
      exp_q.push_back({2'(bank), 4'(row)});
      m_occ++;
      m_refr++;
    end else begin
      m_ovf = 1;
    end
  endtask

  task automatic model_trigger(input int bank, input int row);
    logic [15:0] d;
    int p;
    d = m_lfsr;
    m_lfsr = rng_step(m_lfsr);
    m_trig++;
    if (d < cfg_threshold) begin
      p = m_phys[row];
      if (p > 0)  model_push(bank, slot_owner(p - 1));
      if (p < 15) model_push(bank, slot_owner(p + 1));
    end
  endtask

  // driver: called at posedge+1, leaves sch_valid high on return
  task automatic send(input logic [1:0] cmd, input int bank, input int row);
    sch_valid = 1'b1;
    sch_cmd   = cmd;
    sch_bank  = 2'(bank);
    sch_row   = 4'(row);
    #1;
    while (!sch_ready) begin
      @(posedge clk); #2;
    end
    chk(bus_valid && bus_cmd == cmd && bus_bank == 2'(bank) && bus_row == 4'(row),
        "R7 scheduler command on bus", int'(bus_cmd), int'(cmd));
    if (cmd == 2'd2 && b_open[bank]) model_trigger(bank, b_open[bank] ? b_row[bank] : 0);
    if (cmd == 2'd1) begin b_open[bank] = 1; b_row[bank] = row; end
    if (cmd == 2'd2) b_open[bank] = 0;
    @(posedge clk); #1;
  endtask

  task automatic release_sch();
    sch_valid = 1'b0;
    sch_cmd   = 2'd0;
  endtask

  task automatic access(input int bank, input int row);
    send(2'd1, bank, row);
    send(2'd2, bank, row);
    release_sch();
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // monitor: samples just before each rising edge, scoreboards refresh traffic
  initial begin
    forever begin
      @(posedge clk); #3;
      cyc++;
      if (rst_n && bus_valid && bus_ready && !sch_valid) begin
        if (bus_cmd == 2'd1) begin
          if (exp_q.size() == 0) begin
            chk(0, "R3 unexpected refresh activate", int'(bus_row), -1);
          end else begin
            chk(bus_bank == exp_q[0][5:4] && bus_row == exp_q[0][3:0],
                "R4 R5 refresh target", int'({bus_bank, bus_row}), int'(exp_q[0]));
          end
          act_cyc = cyc;
        end else if (bus_cmd == 2'd2) begin
          chk(cyc - act_cyc >= GAP + 2, "R6 activate-precharge gap", cyc - act_cyc, GAP + 2);
          if (exp_q.size() != 0) begin
            chk(bus_bank == exp_q[0][5:4] && bus_row == exp_q[0][3:0],
                "R5 refresh precharge target", int'({bus_bank, bus_row}), int'(exp_q[0]));
            void'(exp_q.pop_front());
            m_occ--;
          end
        end
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int t0, r0;
    logic [1:0] hold_cmd;
    logic [3:0] hold_row;
    rst_n = 0; cfg_threshold = 0; cfg_gap = 4'(GAP); cfg_seed_load = 0; cfg_seed = 0;
    cfg_map_we = 0; cfg_map_lrow = 0; cfg_map_prow = 0;
    sch_valid = 0; sch_cmd = 0; sch_bank = 0; sch_row = 0; bus_ready = 1;
    for (int l = 0; l < 16; l++) m_phys[l] = l;
    for (int b = 0; b < 4; b++) begin b_open[b] = 0; b_row[b] = 0; end
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    tick();

    // R10 reset state
    chk(!bus_valid, "R10 bus idle after reset", int'(bus_valid), 0);
    chk(!overflow, "R10 overflow clear", int'(overflow), 0);
    chk(trig_count == 0 && refr_count == 0, "R10 counters zero",
        int'(trig_count) + int'(refr_count), 0);

    // R3 zero threshold never refreshes
    for (int i = 0; i < 6; i++) access(i % 4, 5 + i);
    drain();
    chk(refr_count == 0, "R3 zero threshold", int'(refr_count), 0);
    chk(int'(trig_count) == m_trig, "R1 trigger count", int'(trig_count), m_trig);

    // R1 precharge to closed bank and read/write are not triggers
    t0 = int'(trig_count);
    send(2'd2, 2, 7); release_sch(); tick();
    chk(int'(trig_count) == t0, "R1 precharge on closed bank", int'(trig_count), t0);
    send(2'd1, 3, 4); send(2'd3, 3, 4); release_sch(); tick();
    chk(int'(trig_count) == t0, "R1 read/write no trigger", int'(trig_count), t0);
    send(2'd2, 3, 4); release_sch(); tick();
    chk(int'(trig_count) == t0 + 1, "R1 close of open row", int'(trig_count), t0 + 1);
    drain();

    // R2 seed load, zero seed maps to one, then a real seed
    cfg_seed = 16'h0000; cfg_seed_load = 1; tick(); cfg_seed_load = 0; m_lfsr = 16'h0001;
    cfg_seed = 16'hACE1; cfg_seed_load = 1; tick(); cfg_seed_load = 0; m_lfsr = 16'hACE1;
    cfg_threshold = 16'hFFFF;
    for (int i = 0; i < 8; i++) begin access(i % 4, 1 + i); drain(); end
    chk(int'(refr_count) == m_refr, "R2 seeded decisions", int'(refr_count), m_refr);

    // R7 refresh offer held under back-pressure
    access(1, 9);
    bus_ready = 0;
    #1;
    hold_cmd = bus_cmd; hold_row = bus_row;
    for (int k = 0; k < 4; k++) begin
      tick(); #1;
      chk(exp_q.size() == 0 || (bus_valid && bus_cmd == hold_cmd && bus_row == hold_row),
          "R7 offer held while not ready", int'(bus_row), int'(hold_row));
    end
    tick();
    bus_ready = 1;
    drain();

    // R4 remapped neighbours, including rows at both ends of the array
    for (int l = 0; l < 16; l++) begin
      cfg_map_we = 1; cfg_map_lrow = 4'(l); cfg_map_prow = 4'((5 * l + 3) % 16);
      m_phys[l] = (5 * l + 3) % 16;
      tick();
    end
    cfg_map_we = 0;
    r0 = int'(refr_count);
    access(0, 9); drain();
    chk(int'(refr_count) - r0 <= 1, "R4 edge slot has one neighbour", int'(refr_count) - r0, 1);
    r0 = int'(refr_count);
    access(1, 12); drain();
    chk(int'(refr_count) - r0 <= 1, "R4 top slot has one neighbour", int'(refr_count) - r0, 1);
    access(2, 0); drain();
    access(3, 6); drain();
    chk(int'(refr_count) == m_refr, "R4 remap totals", int'(refr_count), m_refr);

    // R8 overflow while the scheduler holds the bus (also R7 stall)
    r0 = int'(refr_count);
    send(2'd1, 0, 4); send(2'd2, 0, 4);
    send(2'd1, 1, 5); send(2'd2, 1, 5);
    send(2'd1, 2, 6); send(2'd2, 2, 6);
    send(2'd3, 2, 6);
    chk(int'(refr_count) == r0, "R7 no refresh while scheduler busy", int'(refr_count), r0);
    release_sch();
    drain();
    chk(overflow == m_ovf, "R8 overflow flag", int'(overflow), int'(m_ovf));
    chk(int'(refr_count) == m_refr, "R8 dropped entries not issued", int'(refr_count), m_refr);

    // R9 observed rate against programmed probability
    cfg_threshold = 16'h4000;
    t0 = int'(trig_count); r0 = int'(refr_count);
    begin
      int m0;
      m0 = m_refr;
      for (int i = 0; i < 320; i++) begin access(i % 4, (i * 7) % 16); drain(); end
      chk(int'(refr_count) - r0 == m_refr - m0, "R9 refresh count matches model",
          int'(refr_count) - r0, m_refr - m0);
      chk(int'(refr_count) - r0 >= 96 && int'(refr_count) - r0 <= 224,
          "R9 rate near one quarter", int'(refr_count) - r0, 150);
    end
    chk(int'(trig_count) - t0 == 320, "R1 triggers in rate run", int'(trig_count) - t0, 320);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule